// File: doc/BRIEF.md
# Vectored External Interrupt Controller

This block gathers eight edge-triggered external interrupt lines and one top-level channel into a single request towards a CPU. Each external line can be set to trigger on its rising or its falling edge. An edge sets a pending flag for that line. The flag stays set until the CPU services it. External lines reach the CPU only while the global enable is on and the line's own enable bit is set.

The top-level channel is pseudo-non-maskable. A configuration bit chooses its source: either a dedicated NMI pin or a watchdog event line. It triggers on the rising edge, ignores the global and per-line enables, and outranks every external line. Among the external lines, line 0 ranks highest and line 7 lowest.

The CPU sees a request line. When it acknowledges a request, the block clears the pending flag of the winning channel. It then presents an 8-bit vector for that channel and holds it until the next acknowledge. For an external line the vector is a software base in the top bits, the channel number below it, and a zero in the last bit. The top-level channel always yields vector 0x04.

Top module: `xirq_vector_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `irq_req_o` is 0 and `irq_vec_o` is 0x00, with every pending flag clear.
- R2: When `edge_rise_i[n]` is 1, a 0-to-1 transition on `ext_irq_i[n]` sets its pending flag and a 1-to-0 transition is ignored; when it is 0 the opposite holds. A level held after one edge yields exactly one request.
- R3: An external pending flag drives `irq_req_o` only while `glob_en_i` is 1 and `chan_en_i[n]` is 1. A flag blocked this way is kept and requests as soon as both enables are 1.
- R4: The top-level source is `nmi_pin_i` when `top_src_wdog_i` is 0 and `wdog_evt_i` when it is 1; the unselected line has no effect. Its rising edge requests regardless of `glob_en_i` and `chan_en_i`, and it wins over every external line.
- R5: The vector for external channel n is {B, n[2:0], 1'b0}, where B is `vec_base_i` (4 bits), with base 0 replaced by 1.
- R6: The top-level channel yields vector 0x04. Vector 0x02 is never produced.
- R7: Among enabled external pending channels, the lowest index is served first.
- R8: `irq_ack_i` high while `irq_req_o` is high clears the winner's flag, and the winner's vector appears on `irq_vec_o` from the next cycle. `irq_vec_o` holds otherwise, including when there is an acknowledge without a request or when the base changes.
- R9: If an edge on a channel is detected in the same cycle that an acknowledge clears that channel's flag, the flag stays set.
- R10: An input transition driven before clock edge k raises `irq_req_o` after edge k+2 (two synchronizer stages, then the pending flag), and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_irq_i | input | 8 | External interrupt lines |
| edge_rise_i | input | 8 | Per-line edge choice: 1 rising, 0 falling |
| chan_en_i | input | 8 | Per-line enable |
| glob_en_i | input | 1 | Global enable for external lines |
| top_src_wdog_i | input | 1 | Top-level source: 0 NMI pin, 1 watchdog event |
| nmi_pin_i | input | 1 | NMI pin |
| wdog_evt_i | input | 1 | Watchdog event line |
| vec_base_i | input | 4 | Software base for external vectors |
| irq_ack_i | input | 1 | CPU acknowledge |
| irq_req_o | output | 1 | Request to CPU |
| irq_vec_o | output | 8 | Vector of the last serviced channel |

## Verification
The assertions assume that the CPU raises `irq_ack_i` only for a single cycle at a time. They also assume that `vec_base_i` and the enables are quasi-static settings, not signals that race the acknowledge. The stimulus follows these assumptions: it changes configuration only between acknowledges, and it raises every acknowledge for exactly one clock. The assertions also assume that an input holds its level for at least two clocks, so that the synchronizer sees every edge. The bench keeps every interrupt line steady for three clocks or more after each change.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
    localparam int unsigned XI_CH     = 8;
    localparam int unsigned XI_BASE_W = 4;
    localparam logic [7:0]  XI_TOP_VEC  = 8'h04;
    localparam logic [7:0]  XI_TRAP_VEC = 8'h02;
endpackage

// File: rtl/xirq_sync_edge.sv
module xirq_sync_edge #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    input  logic [W-1:0] rise_sel_i,
    output logic [W-1:0] hit_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1   = raw_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < W; g++) begin : g_edge
        assign hit_o[g] = rise_sel_i[g] ? ( st_q.s2[g] & ~st_q.prev[g])
                                        : (~st_q.s2[g] &  st_q.prev[g]);
    end
endmodule

// File: rtl/xirq_prio_pick.sv
module xirq_prio_pick #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = 3
) (
    input  logic [N-1:0] ext_elig_i,
    input  logic         top_elig_i,
    output logic         any_o,
    output logic         top_win_o,
    output logic [IW-1:0] idx_o,
    output logic [N:0]   onehot_o
);
    always_comb begin
        any_o     = top_elig_i | (|ext_elig_i);
        top_win_o = top_elig_i;
        idx_o     = '0;
        onehot_o  = '0;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (ext_elig_i[i]) idx_o = IW'(i);
        end
        if (top_elig_i)        onehot_o[N]     = 1'b1;
        else if (|ext_elig_i)  onehot_o[idx_o] = 1'b1;
    end
endmodule

// File: rtl/xirq_vector_ctrl.sv
module xirq_vector_ctrl
    import xirq_pkg::*;
#(
    parameter int unsigned CH_N   = XI_CH,
    parameter int unsigned BASE_W = XI_BASE_W,
    localparam int unsigned IDX_W = $clog2(CH_N),
    localparam int unsigned VEC_W = BASE_W + IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_N-1:0]   ext_irq_i,
    input  logic [CH_N-1:0]   edge_rise_i,
    input  logic [CH_N-1:0]   chan_en_i,
    input  logic              glob_en_i,
    input  logic              top_src_wdog_i,
    input  logic              nmi_pin_i,
    input  logic              wdog_evt_i,
    input  logic [BASE_W-1:0] vec_base_i,
    input  logic              irq_ack_i,
    output logic              irq_req_o,
    output logic [VEC_W-1:0]  irq_vec_o
);
    localparam logic [VEC_W-1:0] TOP_VEC = VEC_W'(XI_TOP_VEC);

    typedef struct packed {
        logic [CH_N:0]    pend;
        logic [VEC_W-1:0] vec;
    } ctl_t;

    ctl_t st_d, st_q;

    logic              top_raw;
    logic [CH_N:0]     hit;
    logic [CH_N-1:0]   ext_elig;
    logic              any_win;
    logic              top_win;
    logic [IDX_W-1:0]  win_idx;
    logic [CH_N:0]     win_hot;

    assign top_raw = top_src_wdog_i ? wdog_evt_i : nmi_pin_i;

    xirq_sync_edge #(.W(CH_N + 1)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_i      ({top_raw, ext_irq_i}),
        .rise_sel_i ({1'b1, edge_rise_i}),
        .hit_o      (hit)
    );

    assign ext_elig = st_q.pend[CH_N-1:0] & chan_en_i & {CH_N{glob_en_i}};

    xirq_prio_pick #(.N(CH_N), .IW(IDX_W)) i_pick (
        .ext_elig_i (ext_elig),
        .top_elig_i (st_q.pend[CH_N]),
        .any_o      (any_win),
        .top_win_o  (top_win),
        .idx_o      (win_idx),
        .onehot_o   (win_hot)
    );

    always_comb begin
        logic              take;
        logic [CH_N:0]     clr;
        logic [BASE_W-1:0] base_eff;
        logic [VEC_W-1:0]  win_vec;
        take     = irq_ack_i & any_win;
        clr      = take ? win_hot : '0;
        base_eff = (vec_base_i == '0) ? BASE_W'(1) : vec_base_i;
        win_vec  = top_win ? TOP_VEC : {base_eff, win_idx, 1'b0};
        st_d.pend = (st_q.pend & ~clr) | hit;
        st_d.vec  = take ? win_vec : st_q.vec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_req_o = any_win;
    assign irq_vec_o = st_q.vec;
endmodule

// File: rtl/xirq_vector_ctrl_chk.sv
module xirq_vector_ctrl_chk
    import xirq_pkg::*;
#(
    parameter int unsigned CH_N   = 8,
    parameter int unsigned BASE_W = 4,
    parameter int unsigned VEC_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq_req_o,
    input logic              irq_ack_i,
    input logic [VEC_W-1:0]  irq_vec_o,
    input logic              glob_en_i,
    input logic [BASE_W-1:0] vec_base_i,
    input logic [CH_N:0]     pend_i
);
    localparam logic [VEC_W-1:0] TOP_VEC  = VEC_W'(XI_TOP_VEC);
    localparam logic [VEC_W-1:0] TRAP_VEC = VEC_W'(XI_TRAP_VEC);

    p_req_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (glob_en_i || pend_i[CH_N]));

    p_top_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && pend_i[CH_N]) |=> (irq_vec_o == TOP_VEC));

    p_vec_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack_i && irq_req_o && !pend_i[CH_N]) |=>
            (irq_vec_o[0] == 1'b0) &&
            (irq_vec_o[VEC_W-1 -: BASE_W] ==
                (($past(vec_base_i) == '0) ? BASE_W'(1) : $past(vec_base_i))));

    p_no_trap_vec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vec_o != TRAP_VEC);

    p_vec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_ack_i && irq_req_o) |=> $stable(irq_vec_o));

    for (genvar g = 0; g <= CH_N; g++) begin : g_keep
        p_pend_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_i[g] && !(irq_ack_i && irq_req_o)) |=> pend_i[g]);
    end
endmodule

bind xirq_vector_ctrl xirq_vector_ctrl_chk #(
    .CH_N(CH_N), .BASE_W(BASE_W), .VEC_W(VEC_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_req_o  (irq_req_o),
    .irq_ack_i  (irq_ack_i),
    .irq_vec_o  (irq_vec_o),
    .glob_en_i  (glob_en_i),
    .vec_base_i (vec_base_i),
    .pend_i     (st_q.pend)
);

// File: tb/test_xirq_vector_ctrl.sv
`timescale 1ns/1ps
module test_xirq_vector_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] ext_irq_i, edge_rise_i, chan_en_i;
    logic       glob_en_i, top_src_wdog_i, nmi_pin_i, wdog_evt_i;
    logic [3:0] vec_base_i;
    logic       irq_ack_i;
    logic       irq_req_o;
    logic [7:0] irq_vec_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    xirq_vector_ctrl i_xirq_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq_i), .edge_rise_i(edge_rise_i),
        .chan_en_i(chan_en_i), .glob_en_i(glob_en_i), .top_src_wdog_i(top_src_wdog_i),
        .nmi_pin_i(nmi_pin_i), .wdog_evt_i(wdog_evt_i), .vec_base_i(vec_base_i),
        .irq_ack_i(irq_ack_i), .irq_req_o(irq_req_o), .irq_vec_o(irq_vec_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack();
        irq_ack_i = 1'b1;
        @(negedge clk);
        irq_ack_i = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ev(input logic [3:0] b, input int c);
        ev = {(b == 4'd0) ? 4'd1 : b, c[2:0], 1'b0};
    endfunction

    function automatic int lowest(input logic [7:0] m);
        lowest = 0;
        for (int i = 7; i >= 0; i--) if (m[i]) lowest = i;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; ext_irq_i = '0; edge_rise_i = 8'hFF; chan_en_i = 8'hFF;
        glob_en_i = 1'b1; top_src_wdog_i = 1'b0; nmi_pin_i = 1'b0; wdog_evt_i = 1'b0;
        vec_base_i = 4'd0; irq_ack_i = 1'b0;
        tick(3);
        chk("R1 req in reset", {7'd0, irq_req_o}, 8'h00);
        chk("R1 vec in reset", irq_vec_o, 8'h00);
        rst_n = 1'b1;
        tick(2);
        chk("R1 req after reset", {7'd0, irq_req_o}, 8'h00);

        // R5 R10 R2 R6: every base against every channel
        for (int b = 0; b < 16; b++) begin
            for (int c = 0; c < 8; c++) begin
                vec_base_i = 4'(b);
                ext_irq_i[c] = 1'b1;
                tick(2);
                chk("R10 not yet", {7'd0, irq_req_o}, 8'h00);
                tick(1);
                chk("R10 request", {7'd0, irq_req_o}, 8'h01);
                ack();
                chk("R5 vector", irq_vec_o, ev(4'(b), c));
                if (b == 0) chk("R6 not trap", {7'd0, irq_vec_o == 8'h02}, 8'h00);
                chk("R2 held level one event", {7'd0, irq_req_o}, 8'h00);
                ext_irq_i[c] = 1'b0;
                tick(3);
                chk("R2 falling ignored", {7'd0, irq_req_o}, 8'h00);
            end
        end

        // R7: all pending patterns, served lowest index first
        vec_base_i = 4'hA;
        for (int p = 1; p < 256; p++) begin
            logic [7:0] rem;
            rem = 8'(p);
            ext_irq_i = 8'(p);
            tick(3);
            while (rem != 0) begin
                int w;
                w = lowest(rem);
                chk("R7 request", {7'd0, irq_req_o}, 8'h01);
                ack();
                chk("R7 order", irq_vec_o, ev(4'hA, w));
                rem[w] = 1'b0;
            end
            chk("R7 drained", {7'd0, irq_req_o}, 8'h00);
            ext_irq_i = '0;
            tick(3);
        end

        // R2 falling mode
        edge_rise_i = 8'h00;
        ext_irq_i = 8'h81;
        tick(3);
        chk("R2 rising ignored", {7'd0, irq_req_o}, 8'h00);
        ext_irq_i = 8'h00;
        tick(3);
        chk("R2 falling request", {7'd0, irq_req_o}, 8'h01);
        ack();
        chk("R2 falling ch0", irq_vec_o, ev(4'hA, 0));
        ack();
        chk("R2 falling ch7", irq_vec_o, ev(4'hA, 7));
        edge_rise_i = 8'hFF;
        tick(3);

        // R3 enables
        glob_en_i = 1'b0;
        ext_irq_i[5] = 1'b1;
        tick(3);
        chk("R3 global off", {7'd0, irq_req_o}, 8'h00);
        glob_en_i = 1'b1;
        tick(1);
        chk("R3 global on kept", {7'd0, irq_req_o}, 8'h01);
        chan_en_i = 8'hDF;
        tick(1);
        chk("R3 line off", {7'd0, irq_req_o}, 8'h00);
        chan_en_i = 8'hFF;
        tick(1);
        chk("R3 line on", {7'd0, irq_req_o}, 8'h01);
        ack();
        chk("R3 vector", irq_vec_o, ev(4'hA, 5));
        ext_irq_i = '0;
        tick(3);

        // R4 top-level channel
        glob_en_i = 1'b0; chan_en_i = 8'h00;
        nmi_pin_i = 1'b1;
        tick(3);
        chk("R4 pin request", {7'd0, irq_req_o}, 8'h01);
        ack();
        chk("R6 top vector pin", irq_vec_o, 8'h04);
        nmi_pin_i = 1'b0;
        tick(3);
        top_src_wdog_i = 1'b1;
        nmi_pin_i = 1'b1;
        tick(3);
        chk("R4 pin unselected", {7'd0, irq_req_o}, 8'h00);
        nmi_pin_i = 1'b0;
        wdog_evt_i = 1'b1;
        tick(3);
        chk("R4 watchdog request", {7'd0, irq_req_o}, 8'h01);
        ack();
        chk("R6 top vector wdog", irq_vec_o, 8'h04);
        wdog_evt_i = 1'b0;
        tick(3);
        glob_en_i = 1'b1; chan_en_i = 8'hFF;
        ext_irq_i[0] = 1'b1; wdog_evt_i = 1'b1;
        tick(3);
        ack();
        chk("R4 top beats ch0", irq_vec_o, 8'h04);
        ack();
        chk("R4 ch0 second", irq_vec_o, ev(4'hA, 0));
        chk("R4 drained", {7'd0, irq_req_o}, 8'h00);
        ext_irq_i = '0; wdog_evt_i = 1'b0; top_src_wdog_i = 1'b0;
        tick(3);

        // R8 hold behaviour
        ack();
        chk("R8 ack without request", irq_vec_o, ev(4'hA, 0));
        vec_base_i = 4'h3;
        tick(1);
        chk("R8 base change holds", irq_vec_o, ev(4'hA, 0));
        vec_base_i = 4'hA;

        // R9 edge meets acknowledge
        ext_irq_i[3] = 1'b1;
        tick(3);
        ext_irq_i[3] = 1'b0;
        tick(3);
        ext_irq_i[3] = 1'b1;
        tick(2);
        ack();
        chk("R9 vector", irq_vec_o, ev(4'hA, 3));
        chk("R9 still pending", {7'd0, irq_req_o}, 8'h01);
        ack();
        chk("R9 second service", irq_vec_o, ev(4'hA, 3));
        chk("R9 drained", {7'd0, irq_req_o}, 8'h00);
        ext_irq_i = '0;
        tick(3);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule